// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Adapter

This block sits between a processor's data port and a single-port memory. Each upstream request carries an address, a write-data word, a write flag and a 6-bit operation code. When the code is zero the request is a plain load or store. The adapter forwards it to memory as one access and returns the memory's response. When the code names an atomic operator, the request arrives with the write flag set. The adapter still reads the old word at the address and returns that word as the response data. It combines the old word with the request's write data using the selected operator, writes the result back to the same address, and only then completes the request.

The adapter handles one request at a time. The upstream request handshake stays low from the moment a request is accepted until its response has been taken. No other access can therefore reach memory between the read and the write-back of an atomic sequence. A downstream error on the read ends the sequence at once, and the write-back is skipped. A downstream error on either access is reported on the single upstream response.

All data channels use valid/ready. A request is accepted on a clock edge where its valid and ready are both high. A source that has raised valid keeps valid high and its fields unchanged until that edge. The upstream response follows the same rule: the adapter holds it until the consumer's ready is high. The downstream response has no ready. The memory presents it for one cycle, and the adapter always takes it, because it keeps at most one downstream access outstanding.

Top module: `amo_adapter`

## Requirements
- R1: After reset `up_req_ready` is 1, and `up_rsp_valid` and `dn_req_valid` are 0. `up_req_ready` is 0 from the edge that accepts a request until the edge that hands over its response.
- R2: A request with code 0 and `up_we`=0 produces exactly one downstream read at `up_addr`. The response carries that read's data and error flag.
- R3: A request with code 0 and `up_we`=1 produces exactly one downstream write of `up_wdata` at `up_addr`. The response error equals that write's error.
- R4: A request with code 1 to 9 produces a downstream read and then a downstream write, both at `up_addr`. The response data is the word returned by the read.
- R5: The stored result is f(old, operand), where operand is `up_wdata`. The codes are 1 swap (operand), 2 add, 3 and, 4 or, 5 xor, 6 signed max, 7 unsigned max, 8 signed min, 9 unsigned min.
- R6: Codes 6 and 8 compare the two words as two's-complement numbers. Codes 7 and 9 compare them as unsigned numbers.
- R7: If the read of an atomic request returns an error, the response has error 1 and no downstream write is issued.
- R8: If the write-back of an atomic request returns an error, the response has error 1 and still carries the old word.
- R9: A code from 10 to 63 is answered with error 1 and makes no downstream access.
- R10: While `dn_req_valid` is 1 and `dn_req_ready` is 0, the downstream request fields stay unchanged. While `up_rsp_valid` is 1 and `up_rsp_ready` is 0, the response stays unchanged.
- R11: At most one downstream access is outstanding. Every downstream access uses the address of the upstream request being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request ready (high only when idle) |
| up_addr | input | ADDR_W | Request address |
| up_we | input | 1 | Request write flag |
| up_wdata | input | DATA_W | Store data or atomic operand |
| up_code | input | CODE_W | Operation code, 0 for plain transfer |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream response ready |
| up_rsp_rdata | output | DATA_W | Read data, or the old word for atomics |
| up_rsp_err | output | 1 | Response error |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request ready |
| dn_addr | output | ADDR_W | Downstream address |
| dn_we | output | 1 | Downstream write flag |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream response valid (one cycle) |
| dn_rsp_rdata | input | DATA_W | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error |

## Verification
The hardest situations to reach are the failures in the middle of an atomic sequence. The read can fail, which must suppress the write-back, or the write-back can fail after the old word has already been captured. In both cases the upstream side shows only one response with the error flag. The bench's memory model arms an error on one chosen word, either on reads or on writes. Directed atomic requests are then aimed at that word, and the number and direction of the memory accesses each request produced are counted. Random ready throttling on both sides, and responses delayed by a random number of cycles, push every state of the sequence through stall cycles.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_SWAP = 4'd1,
    OP_ADD  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_MAX  = 4'd6,
    OP_MAXU = 4'd7,
    OP_MIN  = 4'd8,
    OP_MINU = 4'd9,
    OP_BAD  = 4'd15
  } amo_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_WAIT_RDATA,
    S_WRITE,
    S_WAIT_WACK,
    S_RESP
  } seq_state_e;

  localparam int unsigned LAST_AMO_CODE = 9;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
#(
  parameter int unsigned CODE_W = 6
) (
  input  logic [CODE_W-1:0] code,
  output amo_op_e           op
);

  localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(LAST_AMO_CODE);

  always_comb begin
    if (code == '0) begin
      op = OP_NONE;
    end else if (code <= LAST_CODE) begin
      op = amo_op_e'(code[3:0]);
    end else begin
      op = OP_BAD;
    end
  end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  amo_op_e           op,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] sum;
  logic              lt_signed;
  logic              lt_unsigned;

  assign sum         = old_val + opnd;
  assign lt_signed   = $signed(old_val) < $signed(opnd);
  assign lt_unsigned = old_val < opnd;

  always_comb begin
    unique case (op)
      OP_SWAP: result = opnd;
      OP_ADD:  result = sum;
      OP_AND:  result = old_val & opnd;
      OP_OR:   result = old_val | opnd;
      OP_XOR:  result = old_val ^ opnd;
      OP_MAX:  result = lt_signed   ? opnd : old_val;
      OP_MAXU: result = lt_unsigned ? opnd : old_val;
      OP_MIN:  result = lt_signed   ? old_val : opnd;
      OP_MINU: result = lt_unsigned ? old_val : opnd;
      default: result = old_val;
    endcase
  end

endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_we,
  input  logic [DATA_W-1:0] up_wdata,
  input  amo_op_e           up_op,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [DATA_W-1:0] up_rsp_rdata,
  output logic              up_rsp_err,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_we,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rsp_valid,
  input  logic [DATA_W-1:0] dn_rsp_rdata,
  input  logic              dn_rsp_err,
  output amo_op_e           op_q,
  output logic [DATA_W-1:0] old_q,
  output logic [DATA_W-1:0] opnd_q,
  input  logic [DATA_W-1:0] alu_res
);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic              err_q;
  logic              is_amo;

  assign is_amo = (op_q != OP_NONE) && (op_q != OP_BAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      op_q    <= OP_NONE;
      old_q   <= '0;
      opnd_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (up_req_valid) begin
            addr_q  <= up_addr;
            we_q    <= up_we;
            op_q    <= up_op;
            opnd_q  <= up_wdata;
            old_q   <= '0;
            err_q   <= (up_op == OP_BAD);
            state_q <= (up_op == OP_BAD) ? S_RESP : S_READ;
          end
        end
        S_READ: begin
          if (dn_req_ready) state_q <= S_WAIT_RDATA;
        end
        S_WAIT_RDATA: begin
          if (dn_rsp_valid) begin
            old_q   <= dn_rsp_rdata;
            err_q   <= dn_rsp_err;
            state_q <= (is_amo && !dn_rsp_err) ? S_WRITE : S_RESP;
          end
        end
        S_WRITE: begin
          if (dn_req_ready) state_q <= S_WAIT_WACK;
        end
        S_WAIT_WACK: begin
          if (dn_rsp_valid) begin
            err_q   <= dn_rsp_err;
            state_q <= S_RESP;
          end
        end
        S_RESP: begin
          if (up_rsp_ready) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    up_req_ready = (state_q == S_IDLE);
    up_rsp_valid = (state_q == S_RESP);
    up_rsp_rdata = old_q;
    up_rsp_err   = err_q;
    dn_addr      = addr_q;
    dn_req_valid = 1'b0;
    dn_we        = 1'b0;
    dn_wdata     = opnd_q;
    if (state_q == S_READ) begin
      dn_req_valid = 1'b1;
      dn_we        = is_amo ? 1'b0 : we_q;
    end else if (state_q == S_WRITE) begin
      dn_req_valid = 1'b1;
      dn_we        = 1'b1;
      dn_wdata     = alu_res;
    end
  end

endmodule

// File: rtl/amo_adapter.sv
module amo_adapter
  import amo_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_we,
  input  logic [DATA_W-1:0] up_wdata,
  input  logic [CODE_W-1:0] up_code,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [DATA_W-1:0] up_rsp_rdata,
  output logic              up_rsp_err,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_we,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rsp_valid,
  input  logic [DATA_W-1:0] dn_rsp_rdata,
  input  logic              dn_rsp_err
);

  amo_op_e           dec_op;
  amo_op_e           op_q;
  logic [DATA_W-1:0] old_q;
  logic [DATA_W-1:0] opnd_q;
  logic [DATA_W-1:0] alu_res;

  amo_decode #(.CODE_W(CODE_W)) u_decode (
    .code (up_code),
    .op   (dec_op)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (op_q),
    .old_val (old_q),
    .opnd    (opnd_q),
    .result  (alu_res)
  );

  amo_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_req_valid (up_req_valid),
    .up_req_ready (up_req_ready),
    .up_addr      (up_addr),
    .up_we        (up_we),
    .up_wdata     (up_wdata),
    .up_op        (dec_op),
    .up_rsp_valid (up_rsp_valid),
    .up_rsp_ready (up_rsp_ready),
    .up_rsp_rdata (up_rsp_rdata),
    .up_rsp_err   (up_rsp_err),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_addr      (dn_addr),
    .dn_we        (dn_we),
    .dn_wdata     (dn_wdata),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_rdata (dn_rsp_rdata),
    .dn_rsp_err   (dn_rsp_err),
    .op_q         (op_q),
    .old_q        (old_q),
    .opnd_q       (opnd_q),
    .alu_res      (alu_res)
  );

endmodule

// File: rtl/amo_adapter_chk.sv
module amo_adapter_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_req_valid,
  input logic              up_req_ready,
  input logic [ADDR_W-1:0] up_addr,
  input logic              up_rsp_valid,
  input logic              up_rsp_ready,
  input logic [DATA_W-1:0] up_rsp_rdata,
  input logic              up_rsp_err,
  input logic              dn_req_valid,
  input logic              dn_req_ready,
  input logic [ADDR_W-1:0] dn_addr,
  input logic              dn_we,
  input logic [DATA_W-1:0] dn_wdata,
  input logic              dn_rsp_valid,
  input logic              dn_rsp_err
);

  logic              busy_q;
  logic              dn_pend_q;
  logic              last_we_q;
  logic              rd_err_q;
  logic [ADDR_W-1:0] rec_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      dn_pend_q  <= 1'b0;
      last_we_q  <= 1'b0;
      rd_err_q   <= 1'b0;
      rec_addr_q <= '0;
    end else begin
      if (up_req_valid && up_req_ready) begin
        busy_q     <= 1'b1;
        rec_addr_q <= up_addr;
      end else if (up_rsp_valid && up_rsp_ready) begin
        busy_q <= 1'b0;
      end
      if (dn_req_valid && dn_req_ready) begin
        dn_pend_q <= 1'b1;
        last_we_q <= dn_we;
      end else if (dn_rsp_valid) begin
        dn_pend_q <= 1'b0;
      end
      if (dn_rsp_valid && dn_rsp_err && !last_we_q) begin
        rd_err_q <= 1'b1;
      end else if (up_rsp_valid && up_rsp_ready) begin
        rd_err_q <= 1'b0;
      end
    end
  end

  // R1
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    up_req_ready |-> !busy_q);
  // R1
  p_rsp_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid |-> busy_q);
  // R11
  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> (!dn_pend_q && busy_q));
  // R11
  p_same_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> (dn_addr == rec_addr_q));
  // R7
  p_skip_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> !rd_err_q);
  // R10
  p_dn_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && !dn_req_ready) |=>
      (dn_req_valid && $stable(dn_addr) && $stable(dn_we) && $stable(dn_wdata)));
  // R10
  p_up_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && !up_rsp_ready) |=>
      (up_rsp_valid && $stable(up_rsp_rdata) && $stable(up_rsp_err)));

endmodule

bind amo_adapter amo_adapter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .up_req_valid (up_req_valid),
  .up_req_ready (up_req_ready),
  .up_addr      (up_addr),
  .up_rsp_valid (up_rsp_valid),
  .up_rsp_ready (up_rsp_ready),
  .up_rsp_rdata (up_rsp_rdata),
  .up_rsp_err   (up_rsp_err),
  .dn_req_valid (dn_req_valid),
  .dn_req_ready (dn_req_ready),
  .dn_addr      (dn_addr),
  .dn_we        (dn_we),
  .dn_wdata     (dn_wdata),
  .dn_rsp_valid (dn_rsp_valid),
  .dn_rsp_err   (dn_rsp_err)
);

// File: tb/amo_adapter_tb.sv
`timescale 1ns/1ps
module amo_adapter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_req_valid = 1'b0;
  logic        up_req_ready;
  logic [31:0] up_addr = '0;
  logic        up_we = 1'b0;
  logic [31:0] up_wdata = '0;
  logic [5:0]  up_code = '0;
  logic        up_rsp_valid;
  logic        up_rsp_ready = 1'b0;
  logic [31:0] up_rsp_rdata;
  logic        up_rsp_err;
  logic        dn_req_valid;
  logic        dn_req_ready;
  logic [31:0] dn_addr;
  logic        dn_we;
  logic [31:0] dn_wdata;
  logic        dn_rsp_valid;
  logic [31:0] dn_rsp_rdata;
  logic        dn_rsp_err;

  int unsigned checks = 0;
  int unsigned failures = 0;
  int unsigned cycles = 0;

  always #4 clk = ~clk;

  amo_adapter u_dut (
    .clk(clk), .rst_n(rst_n),
    .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
    .up_addr(up_addr), .up_we(up_we), .up_wdata(up_wdata), .up_code(up_code),
    .up_rsp_valid(up_rsp_valid), .up_rsp_ready(up_rsp_ready),
    .up_rsp_rdata(up_rsp_rdata), .up_rsp_err(up_rsp_err),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
    .dn_addr(dn_addr), .dn_we(dn_we), .dn_wdata(dn_wdata),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_rdata(dn_rsp_rdata), .dn_rsp_err(dn_rsp_err)
  );

  // memory model: 16 words at addr[5:2], random latency, armed errors
  logic [31:0] mem [16];
  logic [31:0] exp_mem [16];
  int unsigned acc_total;
  logic        acc_we_log [16];
  int unsigned lat;
  logic        inj_rd = 1'b0;
  logic        inj_wr = 1'b0;
  logic [3:0]  inj_idx = '0;

  function automatic logic [31:0] init_word(input int i);
    return (32'h9E37_79B9 * (i + 1)) ^ 32'h5A5A_0F0F;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      dn_req_ready <= 1'b0;
      dn_rsp_valid <= 1'b0;
      dn_rsp_rdata <= '0;
      dn_rsp_err   <= 1'b0;
      lat          <= 0;
      acc_total    <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
    end else begin
      dn_rsp_valid <= (lat == 1);
      if (lat != 0) lat <= lat - 1;
      if (dn_req_valid && dn_req_ready) begin
        acc_we_log[acc_total[3:0]] <= dn_we;
        acc_total <= acc_total + 1;
        lat <= 1 + ($urandom % 3);
        if (dn_we) begin
          dn_rsp_rdata <= '0;
          if (inj_wr && dn_addr[5:2] == inj_idx) begin
            dn_rsp_err <= 1'b1;
          end else begin
            dn_rsp_err <= 1'b0;
            mem[dn_addr[5:2]] <= dn_wdata;
          end
        end else begin
          if (inj_rd && dn_addr[5:2] == inj_idx) begin
            dn_rsp_err   <= 1'b1;
            dn_rsp_rdata <= 32'hBAD0_BAD0;
          end else begin
            dn_rsp_err   <= 1'b0;
            dn_rsp_rdata <= mem[dn_addr[5:2]];
          end
        end
      end
      dn_req_ready <= ($urandom % 4) != 0;
    end
  end

  function automatic logic [31:0] ref_op(input logic [5:0] c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      6'd1: return b;
      6'd2: return a + b;
      6'd3: return a & b;
      6'd4: return a | b;
      6'd5: return a ^ b;
      6'd6: return ($signed(a) > $signed(b)) ? a : b;
      6'd7: return (a > b) ? a : b;
      6'd8: return ($signed(a) < $signed(b)) ? a : b;
      6'd9: return (a < b) ? a : b;
      default: return a;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] idx, input logic [31:0] hi, input logic [31:0] wd,
                     input bit we, input logic [5:0] code, input string req);
    logic [31:0] old;
    logic [31:0] r0;
    logic        e0;
    logic [31:0] got_d;
    logic        got_e;
    int unsigned a0;
    int unsigned n;
    int          hold;
    bit          bad;
    bit          amo;
    bit          rerr;
    bit          werr;
    old  = exp_mem[idx];
    bad  = code > 6'd9;
    amo  = (code != 0) && !bad;
    rerr = inj_rd && inj_idx == idx;
    werr = inj_wr && inj_idx == idx;
    a0   = acc_total;
    @(negedge clk);
    up_req_valid = 1'b1;
    up_addr  = (hi & 32'hFFFF_FFC0) | {26'h0, idx, 2'b00};
    up_wdata = wd;
    up_we    = we;
    up_code  = code;
    while (!up_req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    up_req_valid = 1'b0;
    chk(up_req_ready == 1'b0, "R1", "ready low while busy", {31'h0, up_req_ready}, 32'h0);
    while (!up_rsp_valid) @(negedge clk);
    r0 = up_rsp_rdata;
    e0 = up_rsp_err;
    hold = $urandom % 3;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(up_rsp_valid && up_rsp_rdata == r0 && up_rsp_err == e0, "R10",
          "response held under back-pressure", up_rsp_rdata, r0);
    end
    got_d = up_rsp_rdata;
    got_e = up_rsp_err;
    up_rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    up_rsp_ready = 1'b0;
    n = acc_total - a0;
    if (bad) begin
      chk(got_e == 1'b1, req, "bad code error", {31'h0, got_e}, 32'h1);
      chk(n == 0, req, "bad code accesses", n, 0);
    end else if (!amo && !we) begin
      chk(got_e == rerr, req, "plain read error", {31'h0, got_e}, {31'h0, rerr});
      if (!rerr) chk(got_d == old, req, "plain read data", got_d, old);
      chk(n == 1 && acc_we_log[a0[3:0]] == 1'b0, req, "plain read accesses", n, 1);
    end else if (!amo) begin
      chk(got_e == werr, req, "plain write error", {31'h0, got_e}, {31'h0, werr});
      chk(n == 1 && acc_we_log[a0[3:0]] == 1'b1, req, "plain write accesses", n, 1);
      if (!werr) exp_mem[idx] = wd;
    end else if (rerr) begin
      chk(got_e == 1'b1, req, "atomic read error", {31'h0, got_e}, 32'h1);
      chk(n == 1, req, "write skipped after read error", n, 1);
    end else begin
      chk(got_d == old, req, "atomic old word", got_d, old);
      chk(got_e == werr, req, "atomic error", {31'h0, got_e}, {31'h0, werr});
      chk(n == 2 && acc_we_log[a0[3:0]] == 1'b0 && acc_we_log[a0[3:0] + 4'd1] == 1'b1,
          req, "read then write", n, 2);
      if (!werr) exp_mem[idx] = ref_op(code, old, wd);
    end
    chk(mem[idx] == exp_mem[idx], req, "memory word", mem[idx], exp_mem[idx]);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) exp_mem[i] = init_word(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(up_req_ready == 1'b1, "R1", "reset ready", {31'h0, up_req_ready}, 32'h1);
    chk(up_rsp_valid == 1'b0 && dn_req_valid == 1'b0, "R1", "reset valids",
        {30'h0, up_rsp_valid, dn_req_valid}, 32'h0);

    // directed: plain transfers
    run(4'd2, 32'h0, 32'h0, 1'b0, 6'd0, "R2");
    run(4'd2, 32'h1234_0000, 32'hCAFE_F00D, 1'b1, 6'd0, "R3");
    run(4'd2, 32'h0, 32'h0, 1'b0, 6'd0, "R2");
    // directed: every operator
    for (int c = 1; c <= 9; c++) run(4'(c), 32'hABC0_0000, 32'h0F0F_1234 + c, 1'b1, 6'(c), "R5");
    // directed: signed vs unsigned on a word with the top bit set
    exp_mem[7] = exp_mem[7];
    run(4'd7, 32'h0, 32'h8000_0000, 1'b1, 6'd1, "R4");
    run(4'd7, 32'h0, 32'h0000_0001, 1'b1, 6'd6, "R6");
    run(4'd7, 32'h0, 32'h8000_0000, 1'b1, 6'd1, "R4");
    run(4'd7, 32'h0, 32'h0000_0001, 1'b1, 6'd7, "R6");
    run(4'd8, 32'h0, 32'hFFFF_FFFF, 1'b1, 6'd1, "R4");
    run(4'd8, 32'h0, 32'h0000_0002, 1'b1, 6'd8, "R6");
    run(4'd8, 32'h0, 32'hFFFF_FFFF, 1'b1, 6'd1, "R4");
    run(4'd8, 32'h0, 32'h0000_0002, 1'b1, 6'd9, "R6");
    // unsupported codes
    run(4'd3, 32'h0, 32'h1, 1'b1, 6'd10, "R9");
    run(4'd3, 32'h0, 32'h1, 1'b1, 6'd63, "R9");
    // read error on an atomic and a plain read
    inj_idx = 4'd5; inj_rd = 1'b1;
    run(4'd5, 32'h0, 32'h7, 1'b1, 6'd2, "R7");
    run(4'd5, 32'h0, 32'h0, 1'b0, 6'd0, "R2");
    inj_rd = 1'b0;
    // write-back error
    inj_wr = 1'b1;
    run(4'd5, 32'h0, 32'h7, 1'b1, 6'd2, "R8");
    run(4'd5, 32'h0, 32'h9, 1'b1, 6'd0, "R3");
    inj_wr = 1'b0;
    run(4'd5, 32'h0, 32'h7, 1'b1, 6'd2, "R4");

    // constrained random mix
    for (int t = 0; t < 400; t++) begin
      int sel;
      logic [31:0] opnd;
      sel  = $urandom % 12;
      opnd = ($urandom % 4 == 0) ? ($urandom % 8) - 4 : $urandom;
      if (sel < 2)
        run(4'($urandom % 16), $urandom, opnd, 1'($urandom % 2), 6'd0, "R2/R3 random R11");
      else if (sel < 11)
        run(4'($urandom % 16), $urandom, opnd, 1'b1, 6'(sel - 1), "R4/R5 random R11");
      else
        run(4'($urandom % 16), $urandom, opnd, 1'b1, 6'(10 + ($urandom % 54)), "R9");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule